// File: doc/BRIEF.md
# Adaptive Interrupt Pacer

The block sits between a source that signals interrupt events as single-cycle pulses and the interrupt line of a processor. When enabled, it limits how often the processor is interrupted. It adapts a blocking interval to the measured event rate instead of using a fixed coalescing delay. A prescaler divides the core clock into a tick, nominally 4 µs. A fixed number of ticks, nominally 250 for 1 ms, forms a measurement window. At the end of each window the event count is compared against a programmable target rate. The comparison places the rate in one of six bands, and each band moves a reload value differently.

An 8-bit pacing timer counts down on ticks and reloads from that value. While the timer is nonzero, arriving events are merged into one pending flag. When the timer is at zero, one event or the pending flag is released as a single output pulse, and the timer restarts the blocking interval. When the source rate stays well below the target, the reload value settles at zero and events pass with one cycle of latency. When pacing is disabled, the input is wired straight through and all internal state is cleared.

Top module: `irq_pacer`

## Requirements
- R1: While `en_i` is low, `irq_o` equals `irq_i` in the same cycle, and the pacing state (timer, pending flag, reload value, counters) is cleared, so that it restarts from zero when `en_i` rises.
- R2: While enabled, a tick occurs every `prescale_i` clock cycles (a value of 0 acts as 1), counted from the first enabled cycle. A measurement window ends on every `WIN_TICKS`-th tick.
- R3: Every enabled cycle with `irq_i` high counts as one event of the current window, whether or not it is blocked. An event in the cycle that ends a window counts toward the next window. The counter saturates at its maximum.
- R4: At each window end the reload value is updated by the first matching band. The bands are, with c the count, m = `max_i` and p the previous reload value: c > 2m gives 255; 2c > 3m gives 2p+1; c > m gives p+1; 2c > m gives p−1; c ≠ 0 gives p/2; otherwise 0. Results saturate at 255 and at 0. The legal range of m is 2 to 63.
- R5: The pacing timer decrements on each tick while nonzero. While it is zero, it loads the reload value on a tick or when an event is released.
- R6: While the timer is nonzero, no pulse leaves the block. Any number of events arriving in that time collapse into one pending event.
- R7: When the timer is zero and an event arrives or is pending, `irq_o` is high for exactly one cycle, in the cycle after the event is seen. No output occurs without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pacing enable; low gives pass-through |
| irq_i | input | 1 | Raw interrupt event, one event per high cycle |
| prescale_i | input | PRESC_W | Core clock cycles per tick |
| max_i | input | MAX_W | Target events per window (2 to 63) |
| irq_o | output | 1 | Paced interrupt output |

## Verification
The bench builds the pacer with `WIN_TICKS` = 50 and drives `prescale_i` = 2, so one window lasts 100 cycles. The default 8-bit timer and counter widths are kept. With these values every band can be reached by a periodic input with a period of 1 to 30 cycles, and both the 255 ceiling and the floor at zero are reached within a few thousand cycles. The bench infers the reload value from the spacing of output pulses and from the return to one-cycle pass-through.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [2:0] {
    BAND_FLOOD,
    BAND_DOUBLE,
    BAND_INC,
    BAND_DEC,
    BAND_HALF,
    BAND_IDLE
  } pace_band_e;
endpackage

// File: rtl/pace_tick_gen.sv
module pace_tick_gen #(
  parameter int PRESC_W   = 10,
  parameter int WIN_TICKS = 250
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] prescale_i,
  output logic               tick_o,
  output logic               win_end_o
);
  localparam int WIN_W = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);

  logic [PRESC_W-1:0] div_q, div_last;
  logic [WIN_W-1:0]   win_q;

  assign div_last  = (prescale_i == '0) ? '0 : prescale_i - PRESC_W'(1);
  assign tick_o    = en_i && (div_q >= div_last);
  assign win_end_o = tick_o && (win_q == WIN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      win_q <= '0;
    end else if (!en_i) begin
      div_q <= '0;
      win_q <= '0;
    end else if (tick_o) begin
      div_q <= '0;
      win_q <= win_end_o ? '0 : win_q + WIN_W'(1);
    end else begin
      div_q <= div_q + PRESC_W'(1);
    end
  end

  // R2: with a steady prescale above one, ticks never come back to back
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && prescale_i > PRESC_W'(1)) |=> (!tick_o || prescale_i != $past(prescale_i)));
endmodule

// File: rtl/pace_rate_meter.sv
module pace_rate_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             irq_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
    end else if (!en_i) begin
      ev_q <= '0;
    end else if (win_end_i) begin
      ev_q <= irq_i ? CNT_W'(1) : '0;  // boundary event opens the next window
    end else if (irq_i && ev_q != '1) begin
      ev_q <= ev_q + CNT_W'(1);
    end
  end

  assign count_o = ev_q;

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && win_end_i && !irq_i) |=> (count_o == '0));
  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !win_end_i && count_o == '1) |=> (count_o == '1));
endmodule

// File: rtl/pace_reload_calc.sv
module pace_reload_calc
  import pacer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int MAX_W = 6,
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [MAX_W-1:0] max_i,
  output logic [TMR_W-1:0] reload_o
);
  localparam int CW = ((CNT_W > MAX_W) ? CNT_W : MAX_W) + 3;

  logic [CW-1:0]    c_x, m_x;
  pace_band_e       band;
  logic [TMR_W:0]   dbl, inc;
  logic [TMR_W-1:0] reload_q, reload_d;

  assign c_x = CW'(count_i);
  assign m_x = CW'(max_i);

  always_comb begin
    if (c_x > (m_x << 1))                    band = BAND_FLOOD;
    else if ((c_x << 1) > (m_x + (m_x << 1))) band = BAND_DOUBLE;
    else if (c_x > m_x)                      band = BAND_INC;
    else if ((c_x << 1) > m_x)               band = BAND_DEC;
    else if (c_x != '0)                      band = BAND_HALF;
    else                                     band = BAND_IDLE;
  end

  assign dbl = {reload_q, 1'b1};
  assign inc = {1'b0, reload_q} + (TMR_W+1)'(1);

  always_comb begin
    unique case (band)
      BAND_FLOOD:  reload_d = '1;
      BAND_DOUBLE: reload_d = dbl[TMR_W] ? '1 : dbl[TMR_W-1:0];
      BAND_INC:    reload_d = inc[TMR_W] ? '1 : inc[TMR_W-1:0];
      BAND_DEC:    reload_d = (reload_q == '0) ? '0 : reload_q - TMR_W'(1);
      BAND_HALF:   reload_d = reload_q >> 1;
      default:     reload_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '0;
    else if (!en_i)     reload_q <= '0;
    else if (win_end_i) reload_q <= reload_d;
  end

  assign reload_o = reload_q;

  assert_idle_band_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && win_end_i && count_i == '0) |=> (reload_o == '0));
  assert_hold_mid_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !win_end_i) |=> (reload_o == $past(reload_o)));
endmodule

// File: rtl/pace_gate.sv
module pace_gate #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             irq_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic             fire_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             pend_q, fire_q, zero, release_now;

  assign zero        = (tmr_q == '0);
  assign release_now = en_i && zero && (irq_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else if (!en_i) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= release_now;
      if (zero && (tick_i || release_now)) tmr_q <= reload_i;
      else if (tick_i && !zero)            tmr_q <= tmr_q - TMR_W'(1);
      if (release_now)  pend_q <= 1'b0;
      else if (irq_i)   pend_q <= 1'b1;
    end
  end

  assign fire_o = fire_q;

  assert_off_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!fire_o && !pend_q && tmr_q == '0));
  assert_tmr_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !zero) |=> (tmr_q == $past(tmr_q) - TMR_W'(1)));
  assert_blocked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !zero) |=> !fire_o);
  assert_pend_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !zero && irq_i) |=> pend_q);
  assert_fire_needs_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !irq_i && !pend_q) |=> !fire_o);
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int PRESC_W   = 10,
  parameter int WIN_TICKS = 250,
  parameter int CNT_W     = 8,
  parameter int MAX_W     = 6,
  parameter int TMR_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               irq_i,
  input  logic [PRESC_W-1:0] prescale_i,
  input  logic [MAX_W-1:0]   max_i,
  output logic               irq_o
);
  logic             tick, win_end, fire;
  logic [CNT_W-1:0] count;
  logic [TMR_W-1:0] reload;

  pace_tick_gen #(.PRESC_W(PRESC_W), .WIN_TICKS(WIN_TICKS)) u_tick (
    .clk_i, .rst_ni, .en_i, .prescale_i,
    .tick_o(tick), .win_end_o(win_end)
  );

  pace_rate_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni, .en_i, .irq_i,
    .win_end_i(win_end), .count_o(count)
  );

  pace_reload_calc #(.CNT_W(CNT_W), .MAX_W(MAX_W), .TMR_W(TMR_W)) u_calc (
    .clk_i, .rst_ni, .en_i, .win_end_i(win_end),
    .count_i(count), .max_i, .reload_o(reload)
  );

  pace_gate #(.TMR_W(TMR_W)) u_gate (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .irq_i,
    .reload_i(reload), .fire_o(fire)
  );

  assign irq_o = en_i ? fire : irq_i;

  assert_win_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |-> tick);
endmodule

// File: tb/tb_irq_pacer.sv
module tb_irq_pacer;
  logic       clk = 1'b0, rst_ni = 1'b0, en = 1'b0, irq = 1'b0;
  logic [9:0] presc = 10'd2;
  logic [5:0] maxv = 6'd2;
  logic       irq_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_pacer #(.WIN_TICKS(50)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .irq_i(irq),
    .prescale_i(presc), .max_i(maxv), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // one cycle per iteration: sample at negedge, then drive the next input
  task automatic run(input int cycles, input int period,
                     output int n_in, output int n_out, output int max_run);
    int run_len = 0;
    n_in = 0; n_out = 0; max_run = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_o) begin
        n_out++; run_len++;
        if (run_len > max_run) max_run = run_len;
      end else run_len = 0;
      irq = (period > 0) && (i % period == 0);
      if (irq) n_in++;
    end
  endtask

  task automatic restart(input logic [5:0] m);
    @(negedge clk); en = 1'b0; irq = 1'b0;
    @(negedge clk); maxv = m; en = 1'b1;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_o == 1'b0, "R1 reset output", int'(irq_o), 0);
    rst_ni = 1'b1; en = 1'b1;
    repeat (5) @(negedge clk);
    check(irq_o == 1'b0, "R7 no event no pulse", int'(irq_o), 0);
  endtask

  task automatic t_bypass;
    @(negedge clk); en = 1'b0;
    @(negedge clk); irq = 1'b1; #1;
    check(irq_o == 1'b1, "R1 bypass high", int'(irq_o), 1);
    irq = 1'b0; #1;
    check(irq_o == 1'b0, "R1 bypass low", int'(irq_o), 0);
  endtask

  task automatic t_flood;
    int a, b, r;
    restart(6'd2); irq = 1'b1;
    run(300, 1, a, b, r);
    check_rng("R2 R3 first window open cycles", b, 99, 103);
    run(2048, 1, a, b, r);
    check_rng("R4 flood band pulses", b, 3, 5);
    check(r == 1, "R7 single-cycle pulses", r, 1);
    @(negedge clk); irq = 1'b1; en = 1'b0; #1;
    check(irq_o == 1'b1, "R1 disable mid-block", int'(irq_o), 1);
    irq = 1'b0; #1;
    check(irq_o == 1'b0, "R1 disable follows low", int'(irq_o), 0);
  endtask

  task automatic t_recover;
    int a, b, r;
    restart(6'd2); irq = 1'b1;
    run(400, 1, a, b, r);
    run(1200, 0, a, b, r);
    check(b == 1, "R6 blocked events merge into one", b, 1);
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    check(irq_o == 1'b1, "R4 R5 idle band pass latency", int'(irq_o), 1);
    @(negedge clk);
    check(irq_o == 1'b0, "R7 pulse ends", int'(irq_o), 0);
  endtask

  task automatic t_double;
    int a, b, r;
    restart(6'd10);
    run(2000, 6, a, b, r);
    run(2048, 6, a, b, r);
    check_rng("R4 doubling band reaches 255", b, 3, 5);
  endtask

  task automatic t_incdec;
    int a, b, r;
    restart(6'd10);
    run(2000, 8, a, b, r);
    run(1000, 8, a, b, r);
    check_rng("R4 increment band pacing", b, 12, 28);
    run(4200, 14, a, b, r);
    run(1000, 14, a, b, r);
    check(b == a, "R4 R5 decrement floors at 0", b, a);
  endtask

  task automatic t_halve;
    int a, b, r;
    restart(6'd2); irq = 1'b1;
    run(300, 1, a, b, r);
    maxv = 6'd10;
    run(1800, 30, a, b, r);
    run(1000, 30, a, b, r);
    check(b == a, "R4 halving band returns to pass", b, a);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_flood();
    t_recover();
    t_double();
    t_incdec();
    t_halve();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule